// File: doc/BRIEF.md
# Page-Split Scatter-Gather Chain Builder

This block turns one transfer request (a virtual start address, a byte count, an element width and a controller-class flag) into a segment table that a DMA engine can walk. The transfer is cut wherever it crosses a page boundary. Each piece is translated to a physical address through a request/acknowledge lookup port, and the piece's element count is then either folded into the previous table entry or written as a fresh entry.

A piece is folded into the previous entry when its physical address is exactly where the previous physical run stopped. This keeps the table short for buffers whose pages happen to be physically consecutive. When the narrow-controller flag is set, the hardware count field is limited, so folding stops once the merged count would pass 65536 elements. The same flag also forbids 32-bit elements.

When building ends, the block pulses `done` and presents every entry together with the index of the last one. Malformed requests are refused with `err`, and they cause no lookups.

Top module: `sg_chain_builder`

## Requirements
- R1: A piece runs from the current virtual address to the next page boundary (PAGE_BYTES, default 4096), or to the end of the remaining bytes if that comes sooner. A buffer that starts off a page boundary therefore has a short first piece.
- R2: Counts are stored in elements. Width code 0 means bytes (count equals piece bytes), code 1 means 16-bit (piece bytes shifted right by 1), and code 2 means 32-bit (piece bytes shifted right by 2). The shift is applied to each piece before any merge.
- R3: A piece is added to the current entry's count only if its translated address equals the physical end of the previous piece. Otherwise a new entry is opened at the next index, holding that address. The first piece of a request always opens entry 0.
- R4: With the narrow flag set, a merge happens only if the merged count stays at or below 65536 elements. Otherwise a new entry is opened. With the flag clear, no such limit applies.
- R5: A request with the narrow flag and width code 2, or any request with width code 3, is refused with `err`.
- R6: A request with a byte count of zero or above MAX_XFER (default 65536) is refused. `done` and `err` go high together in the cycle after acceptance, and no lookup is issued. A count of exactly MAX_XFER is accepted.
- R7: `done` is high for exactly one cycle, the cycle after the final lookup is acknowledged. At that point `last_idx` equals the number of entries minus one, and entries 0 to `last_idx` hold the table.
- R8: A request is accepted only while `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle. A `req_valid` seen while busy has no effect on the table being built.
- R9: Each piece causes exactly one lookup. `xlat_req` stays high with `xlat_vaddr` equal to the piece's virtual start address until `xlat_ack` is sampled, and `xlat_paddr` is taken in that same cycle.
- R10: After reset, `busy`, `done`, `err` and `xlat_req` are low and `last_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_vaddr | input | ADDR_W | Virtual start address |
| req_bytes | input | LEN_W | Transfer length in bytes |
| req_width | input | 2 | Element width code: 0 byte, 1 16-bit, 2 32-bit |
| req_narrow | input | 1 | Narrow controller: 65536-element cap, no 32-bit |
| busy | output | 1 | Build in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused (with done) |
| xlat_req | output | 1 | Lookup request |
| xlat_vaddr | output | ADDR_W | Virtual address to translate |
| xlat_ack | input | 1 | Lookup answer valid |
| xlat_paddr | input | ADDR_W | Translated physical address |
| seg_addr | output | ENTRIES*ADDR_W | Entry physical addresses, entry i at bits i*ADDR_W |
| seg_count | output | ENTRIES*LEN_W | Entry element counts, entry i at bits i*LEN_W |
| last_idx | output | IDX_W | Index of the last valid entry |

## Verification
A request strobed before edge N shows `busy` after N. A refused request also shows `done` and `err` after N. Each acknowledged lookup updates the table at that edge, and the next piece's address appears on `xlat_vaddr` one cycle later; `done` follows the final acknowledge by exactly one cycle. The bench drives and samples on the falling edge, answers each lookup after 0 to 2 idle cycles, and records the cycle of every acknowledge. It checks the address of each lookup, the one-cycle gap from the last acknowledge to `done`, the single-cycle width of `done`, and that `busy` holds throughout. The whole table is compared against a bench model once `done` is seen.

// File: rtl/sg_pkg.sv
// Shared types for the scatter-gather chain builder.
// Assumes: width codes are fixed by the request interface (0,1,2 legal; 3 refused).
package sg_pkg;

    typedef enum logic [1:0] {
        W_BYTE = 2'd0,
        W_HALF = 2'd1,
        W_WORD = 2'd2,
        W_BAD  = 2'd3
    } width_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_DONE = 2'd2
    } state_e;

endpackage

// File: rtl/sg_piece_calc.sv
// Piece calculator: given the page offset of the current virtual address and
// the bytes still to go, returns the size of the piece that ends at the next
// page boundary (or at the end of the transfer), its element count, and
// whether it is the final piece.
// Assumes: PAGE_BYTES is a power of two and no larger than 2**(LEN_W-1).
module sg_piece_calc
    import sg_pkg::*;
#(
    parameter int PAGE_BYTES = 4096,
    parameter int LEN_W      = 17,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic [OFF_W-1:0] page_off,
    input  logic [LEN_W-1:0] remain,
    input  width_e           width,
    output logic [LEN_W-1:0] piece_bytes,
    output logic [LEN_W-1:0] piece_elems,
    output logic             is_last
);

    localparam logic [LEN_W-1:0] PAGE_L = LEN_W'(PAGE_BYTES);

    logic [LEN_W-1:0] room;

    // Bytes left in the current page, then clip to what remains of the transfer.
    always_comb begin
        room        = PAGE_L - LEN_W'(page_off);
        piece_bytes = (remain < room) ? remain : room;
        is_last     = (remain == piece_bytes);
    end

    // Convert the piece's byte size to elements of the chosen width.
    always_comb begin
        case (width)
            W_HALF:  piece_elems = piece_bytes >> 1;
            W_WORD:  piece_elems = piece_bytes >> 2;
            default: piece_elems = piece_bytes;
        endcase
    end

endmodule

// File: rtl/sg_merge_judge.sv
// Merge judge: decides whether a freshly translated piece extends the current
// table entry, and supplies the merged element count.
// Assumes: prev_cnt is the element count of the entry being extended.
module sg_merge_judge #(
    parameter int ADDR_W       = 32,
    parameter int LEN_W        = 17,
    parameter int NARROW_LIMIT = 65536
) (
    input  logic              have_run,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [ADDR_W-1:0] run_end,
    input  logic              narrow,
    input  logic [LEN_W-1:0]  prev_cnt,
    input  logic [LEN_W-1:0]  elems,
    output logic              merge,
    output logic [LEN_W-1:0]  merged_cnt
);

    localparam logic [LEN_W:0] LIMIT_L = (LEN_W + 1)'(NARROW_LIMIT);

    logic [LEN_W:0] sum;
    logic           fits;

    // Sum one bit wider than the count so the cap comparison cannot wrap.
    always_comb begin
        sum        = {1'b0, prev_cnt} + {1'b0, elems};
        fits       = !narrow || (sum <= LIMIT_L);
        merge      = have_run && (paddr == run_end) && fits;
        merged_cnt = sum[LEN_W-1:0];
    end

endmodule

// File: rtl/sg_seg_table.sv
// Segment table: one address and one count register per entry, a single write
// port (address written only for a new entry), one count read port, and flat
// outputs of the whole table.
// Assumes: wr_idx and rd_idx stay below ENTRIES when used.
module sg_seg_table #(
    parameter int ENTRIES = 17,
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 17,
    parameter int IDX_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_new,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LEN_W-1:0]          wr_cnt,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [LEN_W-1:0]          rd_cnt,
    output logic [ENTRIES*ADDR_W-1:0] flat_addr,
    output logic [ENTRIES*LEN_W-1:0]  flat_cnt
);

    logic [ADDR_W-1:0] addr_r [ENTRIES];
    logic [LEN_W-1:0]  cnt_r  [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // Entry register: count on every write, address only when opening.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_r[e] <= '0;
                cnt_r[e]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                cnt_r[e] <= wr_cnt;
                if (wr_new) begin
                    addr_r[e] <= wr_addr;
                end
            end
        end
        assign flat_addr[e*ADDR_W +: ADDR_W] = addr_r[e];
        assign flat_cnt[e*LEN_W +: LEN_W]    = cnt_r[e];
    end

    // Count read mux for the merge judge.
    always_comb begin
        rd_cnt = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (rd_idx == IDX_W'(e)) begin
                rd_cnt = cnt_r[e];
            end
        end
    end

endmodule

// File: rtl/sg_chain_builder.sv
// Scatter-gather chain builder top. Accepts a request while idle, checks it,
// then walks the transfer one page piece at a time: each piece is translated
// through the lookup port and either merged into the current entry or written
// as a new one. Pulses done (with err for refused requests) when finished.
// Assumes: the lookup responder holds xlat_paddr valid in the xlat_ack cycle;
// MAX_XFER is a multiple of PAGE_BYTES and ADDR_W >= LEN_W.
module sg_chain_builder
    import sg_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int PAGE_BYTES   = 4096,
    parameter int MAX_XFER     = 65536,
    parameter int NARROW_LIMIT = 65536,
    localparam int LEN_W       = $clog2(MAX_XFER) + 1,
    localparam int ENTRIES     = MAX_XFER / PAGE_BYTES + 1,
    localparam int IDX_W       = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_vaddr,
    input  logic [LEN_W-1:0]          req_bytes,
    input  logic [1:0]                req_width,
    input  logic                      req_narrow,
    output logic                      busy,
    output logic                      done,
    output logic                      err,
    output logic                      xlat_req,
    output logic [ADDR_W-1:0]         xlat_vaddr,
    input  logic                      xlat_ack,
    input  logic [ADDR_W-1:0]         xlat_paddr,
    output logic [ENTRIES*ADDR_W-1:0] seg_addr,
    output logic [ENTRIES*LEN_W-1:0]  seg_count,
    output logic [IDX_W-1:0]          last_idx
);

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_XFER);

    state_e            state_q;
    logic [ADDR_W-1:0] vaddr_q;
    logic [LEN_W-1:0]  remain_q;
    width_e            width_q;
    logic              narrow_q;
    logic              have_run_q;
    logic [ADDR_W-1:0] run_end_q;
    logic [IDX_W-1:0]  idx_q;
    logic              err_q;

    logic [LEN_W-1:0]  piece_bytes;
    logic [LEN_W-1:0]  piece_elems;
    logic              is_last;
    logic              merge;
    logic [LEN_W-1:0]  merged_cnt;
    logic [LEN_W-1:0]  cur_cnt;
    logic [IDX_W-1:0]  new_idx;
    logic              take;
    logic              bad_req;
    width_e            req_w;

    sg_piece_calc #(
        .PAGE_BYTES (PAGE_BYTES),
        .LEN_W      (LEN_W)
    ) u_piece (
        .page_off    (vaddr_q[OFF_W-1:0]),
        .remain      (remain_q),
        .width       (width_q),
        .piece_bytes (piece_bytes),
        .piece_elems (piece_elems),
        .is_last     (is_last)
    );

    sg_merge_judge #(
        .ADDR_W       (ADDR_W),
        .LEN_W        (LEN_W),
        .NARROW_LIMIT (NARROW_LIMIT)
    ) u_merge (
        .have_run   (have_run_q),
        .paddr      (xlat_paddr),
        .run_end    (run_end_q),
        .narrow     (narrow_q),
        .prev_cnt   (cur_cnt),
        .elems      (piece_elems),
        .merge      (merge),
        .merged_cnt (merged_cnt)
    );

    sg_seg_table #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W),
        .IDX_W   (IDX_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (take),
        .wr_new    (!merge),
        .wr_idx    (merge ? idx_q : new_idx),
        .wr_addr   (xlat_paddr),
        .wr_cnt    (merge ? merged_cnt : piece_elems),
        .rd_idx    (idx_q),
        .rd_cnt    (cur_cnt),
        .flat_addr (seg_addr),
        .flat_cnt  (seg_count)
    );

    // Request screening and per-piece control terms.
    always_comb begin
        req_w   = width_e'(req_width);
        bad_req = (req_bytes == '0) || (req_bytes > MAX_L) ||
                  (req_w == W_BAD) || (req_narrow && (req_w == W_WORD));
        take    = (state_q == ST_LOOK) && xlat_ack;
        new_idx = have_run_q ? (idx_q + 1'b1) : '0;
    end

    // Sequencer: accept, walk pieces on each lookup answer, then signal done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            vaddr_q    <= '0;
            remain_q   <= '0;
            width_q    <= W_BYTE;
            narrow_q   <= 1'b0;
            have_run_q <= 1'b0;
            run_end_q  <= '0;
            idx_q      <= '0;
            err_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q    <= req_vaddr;
                        remain_q   <= req_bytes;
                        width_q    <= req_w;
                        narrow_q   <= req_narrow;
                        have_run_q <= 1'b0;
                        err_q      <= bad_req;
                        state_q    <= bad_req ? ST_DONE : ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (xlat_ack) begin
                        vaddr_q    <= vaddr_q + ADDR_W'(piece_bytes);
                        remain_q   <= remain_q - piece_bytes;
                        run_end_q  <= xlat_paddr + ADDR_W'(piece_bytes);
                        have_run_q <= 1'b1;
                        if (!merge) begin
                            idx_q <= new_idx;
                        end
                        if (is_last) begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Output decode from the sequencer state.
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_DONE);
        err        = done && err_q;
        xlat_req   = (state_q == ST_LOOK);
        xlat_vaddr = vaddr_q;
        last_idx   = idx_q;
    end

endmodule

// File: rtl/sg_chain_checker.sv
// Protocol checker for the chain builder, attached by bind below.
// Assumes: the same parameter values as the bound instance.
module sg_chain_checker #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int MAX_XFER   = 65536,
    localparam int LEN_W     = $clog2(MAX_XFER) + 1,
    localparam int ENTRIES   = MAX_XFER / PAGE_BYTES + 1,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [LEN_W-1:0]  req_bytes,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              xlat_req,
    input logic              xlat_ack,
    input logic [ADDR_W-1:0] xlat_vaddr,
    input logic [IDX_W-1:0]  last_idx
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ENTRIES - 1);

    // R7: completion is a single-cycle pulse.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the last index never points outside the table.
    p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_idx <= TOP_IDX);

    // R6: a refusal is always reported together with done.
    p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R6: a zero-length request never reaches the lookup port.
    p_zero_no_lookup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && (req_bytes == '0)) |=> (done && !xlat_req));

    // R8: done falls inside the busy window.
    p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R8: an idle builder issues nothing.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!xlat_req && !done));

    // R8: a request seen while idle starts the busy window next cycle.
    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R9: an unanswered lookup keeps asking for the same address.
    p_lookup_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req && !xlat_ack) |=> (xlat_req && $stable(xlat_vaddr)));

endmodule

bind sg_chain_builder sg_chain_checker #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .MAX_XFER   (MAX_XFER)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_bytes  (req_bytes),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .xlat_req   (xlat_req),
    .xlat_ack   (xlat_ack),
    .xlat_vaddr (xlat_vaddr),
    .last_idx   (last_idx)
);

// File: tb/sim_sg_chain_builder.sv
`timescale 1ns/1ps
// Bench for the chain builder: directed corners plus seeded random requests,
// lookups answered from a bench translation function, tables compared
// against a bench model.
module sim_sg_chain_builder;

    localparam int ADDR_W  = 32;
    localparam int PAGE    = 4096;
    localparam int MAXX    = 131072;
    localparam int LEN_W   = $clog2(MAXX) + 1;
    localparam int ENTRIES = MAXX / PAGE + 1;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      req_valid = 1'b0;
    logic [ADDR_W-1:0]         req_vaddr = '0;
    logic [LEN_W-1:0]          req_bytes = '0;
    logic [1:0]                req_width = '0;
    logic                      req_narrow = 1'b0;
    logic                      busy, done, err, xlat_req;
    logic [ADDR_W-1:0]         xlat_vaddr;
    logic                      xlat_ack = 1'b0;
    logic [ADDR_W-1:0]         xlat_paddr = '0;
    logic [ENTRIES*ADDR_W-1:0] seg_addr;
    logic [ENTRIES*LEN_W-1:0]  seg_count;
    logic [IDX_W-1:0]          last_idx;

    int checks = 0;
    int errors = 0;

    longint exp_addr [64];
    longint exp_cnt  [64];
    int     exp_last;
    int     exp_look;

    always #10 clk = ~clk;

    sg_chain_builder #(
        .ADDR_W   (ADDR_W),
        .PAGE_BYTES (PAGE),
        .MAX_XFER (MAXX)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
        .req_vaddr (req_vaddr), .req_bytes (req_bytes),
        .req_width (req_width), .req_narrow (req_narrow),
        .busy (busy), .done (done), .err (err),
        .xlat_req (xlat_req), .xlat_vaddr (xlat_vaddr),
        .xlat_ack (xlat_ack), .xlat_paddr (xlat_paddr),
        .seg_addr (seg_addr), .seg_count (seg_count), .last_idx (last_idx)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bench page map: 0 all contiguous, 1 scattered, 2 runs of three pages.
    function automatic logic [31:0] xlat_fn(input logic [31:0] va, input int mode);
        logic [31:0] vp;
        logic [31:0] off;
        vp  = va / PAGE;
        off = va % PAGE;
        case (mode)
            0:       return va + 32'h0100_0000;
            1:       return (((vp * 13) + 5) & 32'h000F_FFFF) * PAGE + off;
            default: return (vp + 2 * (vp / 3) + 32'h300) * PAGE + off;
        endcase
    endfunction

    // Model of the table from the requirements.
    task automatic model(input logic [31:0] va0, input longint bytes, input int w,
                         input bit narrow, input int mode);
        logic [31:0] va;
        logic [31:0] pa;
        logic [31:0] run_end;
        longint rem, room, piece, el;
        int n;
        va = va0; rem = bytes; n = -1; run_end = '0; exp_look = 0;
        while (rem > 0) begin
            room  = PAGE - (va % PAGE);
            piece = (rem < room) ? rem : room;
            el    = (w == 1) ? (piece >> 1) : (w == 2) ? (piece >> 2) : piece;
            pa    = xlat_fn(va, mode);
            exp_look++;
            if (n >= 0 && pa == run_end && (!narrow || exp_cnt[n] + el <= 65536)) begin
                exp_cnt[n] += el;
            end else begin
                n++;
                exp_addr[n] = pa;
                exp_cnt[n]  = el;
            end
            run_end = pa + 32'(piece);
            va      = va + 32'(piece);
            rem     = rem - piece;
        end
        exp_last = n;
    endtask

    // One request: drive it, answer lookups, check timing and the table.
    task automatic run(input logic [31:0] va, input longint bytes, input int w,
                       input bit narrow, input int mode, input bit poke,
                       input bit want_err, input string tag);
        int cyc, looks, bad_va, busy_gap, wait_cnt, done_cyc, last_ack;
        bit seen, got_err;
        logic [31:0] nva;
        longint rem, room, piece;
        if (!want_err) model(va, bytes, w, narrow, mode);
        @(negedge clk);
        req_vaddr = va; req_bytes = LEN_W'(bytes); req_width = 2'(w);
        req_narrow = narrow; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0; looks = 0; bad_va = 0; busy_gap = 0; seen = 0; got_err = 0;
        done_cyc = -1; last_ack = -10; wait_cnt = $urandom % 3;
        nva = va; rem = bytes;
        while (!seen && cyc < 4000) begin
            if (!busy) busy_gap++;
            xlat_ack  = 1'b0;
            req_valid = 1'b0;
            if (done) begin
                seen = 1; done_cyc = cyc; got_err = err;
            end else begin
                if (poke && cyc == 1) begin
                    req_vaddr = 32'h0000_0010; req_bytes = LEN_W'(5);
                    req_width = 2'd0; req_valid = 1'b1;
                end
                if (xlat_req) begin
                    if (wait_cnt == 0) begin
                        if (xlat_vaddr != nva) bad_va++;
                        xlat_ack   = 1'b1;
                        xlat_paddr = xlat_fn(xlat_vaddr, mode);
                        looks++;
                        last_ack = cyc;
                        room  = PAGE - (nva % PAGE);
                        piece = (rem < room) ? rem : room;
                        nva   = nva + 32'(piece);
                        rem   = rem - piece;
                        wait_cnt = $urandom % 3;
                    end else begin
                        wait_cnt--;
                    end
                end
                @(negedge clk);
                cyc++;
            end
        end
        xlat_ack = 1'b0;
        req_valid = 1'b0;
        chk(seen, {tag, " done seen (watchdog)"}, seen, 1);
        chk(busy_gap == 0, "R8 busy held to done", busy_gap, 0);
        chk(got_err == want_err, want_err ? {tag, " err flag"} : "R7 err low", got_err, want_err);
        if (want_err) begin
            chk(looks == 0, "R6 no lookup on refusal", looks, 0);
            chk(done_cyc == 0, "R6 refusal latency", done_cyc, 0);
        end else begin
            chk(looks == exp_look, "R9 lookup count", looks, exp_look);
            chk(bad_va == 0, "R9 lookup address", bad_va, 0);
            chk(done_cyc == last_ack + 1, "R7 done after last ack", done_cyc, last_ack + 1);
            chk(int'(last_idx) == exp_last, "R7 last_idx", last_idx, exp_last);
            for (int i = 0; i <= exp_last && i < ENTRIES; i++) begin
                chk(seg_addr[i*ADDR_W +: ADDR_W] == 32'(exp_addr[i]), {tag, " entry addr"},
                    seg_addr[i*ADDR_W +: ADDR_W], exp_addr[i]);
                chk(longint'(seg_count[i*LEN_W +: LEN_W]) == exp_cnt[i], {tag, " entry count"},
                    seg_count[i*LEN_W +: LEN_W], exp_cnt[i]);
            end
        end
        @(negedge clk);
        chk(!done, "R7 done single cycle", done, 0);
        chk(!busy, "R8 idle after done", busy, 0);
    endtask

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && !xlat_req, "R10 reset outputs", {busy, done, err, xlat_req}, 0);
        chk(last_idx == '0, "R10 reset last_idx", last_idx, 0);

        // R3: three contiguous aligned pages fold to one entry.
        run(32'h0001_0000, 12288, 0, 0, 0, 0, 0, "R3 contiguous");
        chk(last_idx == '0, "R3 single entry", last_idx, 0);
        // R1: unaligned start, short first piece.
        run(32'h0000_1F00, 600, 0, 0, 1, 0, 0, "R1 unaligned");
        chk(seg_count[0 +: LEN_W] == LEN_W'(256), "R1 short first piece", seg_count[0 +: LEN_W], 256);
        // R2: 16-bit and 32-bit element counts.
        run(32'h0002_0000, 8192, 1, 0, 1, 0, 0, "R2 half");
        chk(seg_count[0 +: LEN_W] == LEN_W'(2048), "R2 half count", seg_count[0 +: LEN_W], 2048);
        run(32'h0003_0000, 4096, 2, 0, 0, 0, 0, "R2 word");
        chk(seg_count[0 +: LEN_W] == LEN_W'(1024), "R2 word count", seg_count[0 +: LEN_W], 1024);
        // R4: narrow cap splits a fully contiguous maximum transfer.
        run(32'h0004_0000, MAXX, 0, 1, 0, 0, 0, "R4 narrow cap");
        chk(last_idx == IDX_W'(1), "R4 narrow two entries", last_idx, 1);
        // R6 and R4: exactly maximum accepted, no cap when not narrow.
        run(32'h0004_0000, MAXX, 0, 0, 0, 0, 0, "R6 max accepted");
        chk(last_idx == '0, "R4 wide no cap", last_idx, 0);
        // R3: runs of three pages.
        run(32'h0000_0800, 20000, 0, 0, 2, 0, 0, "R3 runs");
        // R5 and R6: refusals.
        run(32'h0000_0000, 4096, 2, 1, 0, 0, 1, "R5 narrow word");
        run(32'h0000_0000, 4096, 3, 0, 0, 0, 1, "R5 width code 3");
        run(32'h0000_0000, 0, 0, 0, 0, 0, 1, "R6 zero bytes");
        run(32'h0000_0000, MAXX + 1, 0, 0, 0, 0, 1, "R6 over maximum");
        // R8: a request while busy leaves the table unchanged.
        run(32'h0005_0100, 9000, 0, 0, 1, 1, 0, "R8 ignored request");

        for (int k = 0; k < 30; k++) begin
            int w, mode;
            bit nar;
            longint by;
            logic [31:0] va;
            w    = $urandom % 3;
            nar  = 1'($urandom % 2);
            if (nar && w == 2) w = 1;
            mode = $urandom % 3;
            by   = 1 + ($urandom % MAXX);
            va   = $urandom & 32'h0FFF_FFFF;
            run(va, by, w, nar, mode, 0, 0, "R3 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule